// File: doc/BRIEF.md
# Shared Noise Source Generator

This block produces one pseudo-random noise level that three sound channels share. It runs from a system clock and accepts a 1 MHz clock-enable pulse. A divide-by-16 prescaler turns that enable into a slow tick. A period counter then divides the tick again by a 5-bit programmed period. At the end of each period the block advances a 17-bit feedback shift register and updates the single-bit noise level. Every channel samples this level, so all three hear the same noise at the same rate.

The period counter is a two-state controller. In `S_WAIT` it counts prescaler ticks. When a tick arrives and the count has reached the terminal value (effective period minus one), the transition `wait_to_fire` moves it to `S_FIRE`. `S_FIRE` lasts one clock and drives the update strobe for the shift register. It always leaves by `fire_to_wait` on the next clock. A period of zero is treated as one. The terminal compare is "count at or above terminal", so a new period written while the block is running takes effect at the next compare. The shift register is not restarted when this happens. A parameter selects whether the shift register contents also appear on a debug output.

Top module: `noise_source_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, the shift register holds seed 17'h00001 and `noise_o` is 0 until the first update.
- R2: With period p (1..31), exactly one update occurs for every 16*p clock cycles on which `ce_1m` is high.
- R3: A period value of 0 produces exactly the same update timing and sequence as a period value of 1.
- R4: On each update the shift register shifts right by one. Bit 16 receives the old bit 0 XOR the old bit 3 (bit 0 is the least significant bit of `lfsr_dbg_o`).
- R5: On each update `noise_o` becomes its previous value XOR the shift register's old bit 0. It toggles when that bit is 1 and holds when it is 0.
- R6: Between updates, including any stretch with `ce_1m` low, `noise_o` and the shift register do not change.
- R7: If the period changes while the block is running, the new value is compared at the next prescaler tick. An update fires there if the running count is at or above the new period minus one. The shift register is never reset by the change.
- R8: The shift register never holds all zeros.
- R9: An update becomes visible on `noise_o` and `lfsr_dbg_o` one clock after the rising edge that sampled the `ce_1m` pulse completing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_1m | input | 1 | 1 MHz clock-enable pulse |
| period_i | input | 5 | Programmed noise period (0 acts as 1) |
| noise_o | output | 1 | Shared noise level |
| lfsr_dbg_o | output | 17 | Shift register contents (zero when the debug view is disabled) |

## Verification
A wrong tap, wrong shift direction or wrong level rule shows up on `lfsr_dbg_o` at the first update after the fault. It reaches `noise_o` within a few updates, because the bench compares every update against a software model over long runs. A miscounting prescaler or period counter moves the update by at least one enable pulse. The bench samples one cycle after the exact pulse that should complete each period, so such a fault appears on the very first period. A lost or corrupted seed appears immediately after reset.

// File: rtl/noise_pkg.sv
package noise_pkg;
    localparam int LFSR_W   = 17;
    localparam int PRE_W    = 4;
    localparam int PER_W    = 5;
    localparam int TAP_A    = 0;
    localparam int TAP_B    = 3;
    localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

    typedef enum logic [0:0] {
        S_WAIT = 1'b0,
        S_FIRE = 1'b1
    } per_state_t;
endpackage

// File: rtl/noise_prescale.sv
module noise_prescale
    import noise_pkg::*;
#(
    parameter int DIV_W = PRE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    output logic pre_tick
);
    localparam logic [DIV_W-1:0] LAST = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)  cnt_q <= '0;
        else if (ce) cnt_q <= cnt_q + 1'b1;
    end

    always_comb pre_tick = ce && (cnt_q == LAST);

    // R2: a prescaler tick is only ever produced on an enable pulse
    a_r2_tick_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |-> ce);
endmodule

// File: rtl/noise_period_fsm.sv
module noise_period_fsm
    import noise_pkg::*;
#(
    parameter int CNT_W = PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic [CNT_W-1:0] period,
    output logic             step
);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP_T = {CNT_W{1'b1}} - ONE;

    per_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] term_val;
    logic             at_term;

    always_comb begin
        eff      = (period == '0) ? ONE : period;
        term_val = eff - ONE;
        at_term  = (cnt_q >= term_val);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT: if (pre_tick && at_term) state_d = S_FIRE;  // wait_to_fire
            S_FIRE: state_d = S_WAIT;                           // fire_to_wait
            default: state_d = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (pre_tick) cnt_q <= at_term ? '0 : cnt_q + 1'b1;
    end

    always_comb begin
        unique case (state_q)
            S_FIRE:  step = 1'b1;
            default: step = 1'b0;
        endcase
    end

    // R2: the update strobe is a single-cycle pulse
    a_r2_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIRE) |=> (state_q == S_WAIT));
    // R7: lowering the period never lets the count run past the largest terminal value
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP_T);
    // R3: a zero period fires on every prescaler tick
    a_r3_zero_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && period == '0 && state_q == S_WAIT) |=> (state_q == S_FIRE));
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] sr,
    output logic              level
);
    logic [LFSR_W-1:0] sr_q;
    logic              lvl_q;
    logic              fb;

    always_comb fb = sr_q[TAP_A] ^ sr_q[TAP_B];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= SEED;
            lvl_q <= 1'b0;
        end else if (step) begin
            sr_q  <= {fb, sr_q[LFSR_W-1:1]};
            lvl_q <= lvl_q ^ sr_q[TAP_A];
        end
    end

    always_comb begin
        sr    = sr_q;
        level = lvl_q;
    end

    // R8: never all zeros
    a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);
    // R6: nothing moves without an update strobe
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(sr_q) && $stable(lvl_q)));
    // R5: the level flips exactly when the shifted-out bit was 1
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (lvl_q != $past(lvl_q)) == $past(sr_q[0]));
    // R4: the old upper bits appear one place lower
    a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (sr_q[LFSR_W-2:0] == $past(sr_q[LFSR_W-1:1])));
endmodule

// File: rtl/noise_source_gen.sv
module noise_source_gen
    import noise_pkg::*;
#(
    parameter bit DBG_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_1m,
    input  logic [PER_W-1:0]  period_i,
    output logic              noise_o,
    output logic [LFSR_W-1:0] lfsr_dbg_o
);
    logic              pre_tick;
    logic              step;
    logic [LFSR_W-1:0] sr;

    noise_prescale #(.DIV_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce_1m),
        .pre_tick (pre_tick)
    );

    noise_period_fsm #(.CNT_W(PER_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_tick (pre_tick),
        .period   (period_i),
        .step     (step)
    );

    noise_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .sr    (sr),
        .level (noise_o)
    );

    generate
        if (DBG_EN) begin : g_dbg
            always_comb lfsr_dbg_o = sr;
        end else begin : g_nodbg
            always_comb lfsr_dbg_o = '0;
        end
    endgenerate

    // R9: an update strobe always follows a prescaler tick by one clock
    a_r9_step_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> $past(pre_tick));
endmodule

// File: tb/tb_noise_source_gen.sv
module tb_noise_source_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_1m = 1'b0;
    logic [4:0]  period_i = 5'd1;
    logic        noise_o;
    logic [16:0] lfsr_dbg_o;

    int total = 0;
    int bad   = 0;

    logic [16:0] m_sr;
    logic        m_lvl;

    // stimulus table: period, number of updates
    localparam int NV = 5;
    localparam int VP [NV] = '{1, 0, 31, 5, 17};
    localparam int VN [NV] = '{1200, 1200, 120, 100, 40};

    always #5 clk = ~clk;

    noise_source_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_1m      (ce_1m),
        .period_i   (period_i),
        .noise_o    (noise_o),
        .lfsr_dbg_o (lfsr_dbg_o)
    );

    task automatic model_step();
        logic nb;
        nb    = m_sr[0] ^ m_sr[3];
        m_lvl = m_lvl ^ m_sr[0];
        m_sr  = {nb, m_sr[16:1]};
    endtask

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, {1'b0, lfsr_dbg_o}, {1'b0, m_sr});
        chk(req, {17'b0, noise_o}, {17'b0, m_lvl});
    endtask

    // n enable pulses on consecutive cycles; returns at a negedge right after the last one
    task automatic pulses(input int n);
        @(negedge clk);
        ce_1m = 1'b1;
        repeat (n) @(negedge clk);
        ce_1m = 1'b0;
    endtask

    task automatic run_steps(input int p, input int n, input string req);
        int eff;
        eff = (p == 0) ? 1 : p;
        period_i = 5'(p);
        for (int i = 0; i < n; i++) begin
            pulses(16 * eff);
            @(negedge clk);
            model_step();
            chk_state(req);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_sr  = 17'h00001;
        m_lvl = 1'b0;
        repeat (3) @(negedge clk);
        // R1: seed during reset
        chk_state("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 after reset");

        // R9/R2: exact latency of the first update with period 1
        period_i = 5'd1;
        pulses(15);
        @(negedge clk);
        chk_state("R2 no update after 15 pulses");
        pulses(1);
        chk_state("R9 not yet visible");
        @(negedge clk);
        model_step();
        chk_state("R9 visible one clock later");
        chk("R5 first toggle", {17'b0, noise_o}, 18'd1);
        chk("R4 first shift", {1'b0, lfsr_dbg_o}, 18'h10000);

        // table: R2 R3 R4 R5 R8 over long runs
        for (int v = 0; v < NV; v++) begin
            run_steps(VP[v], VN[v], (VP[v] == 0) ? "R3 period zero" : "R4/R5 sequence");
        end
        chk("R8 nonzero", {17'b0, lfsr_dbg_o != 17'h0}, 18'd1);

        // R7: lower the period mid-count
        period_i = 5'd31;
        pulses(48);
        @(negedge clk);
        chk_state("R7 no update before change");
        period_i = 5'd2;
        pulses(16);
        @(negedge clk);
        model_step();
        chk_state("R7 fires at next compare");
        pulses(31);
        @(negedge clk);
        chk_state("R7 new period holds");
        pulses(1);
        @(negedge clk);
        model_step();
        chk_state("R7 new period fires");

        // R6: enable low leaves everything untouched
        repeat (50) @(negedge clk);
        chk_state("R6 idle hold");
        period_i = 5'd0;
        repeat (20) @(negedge clk);
        chk_state("R6 period change alone");

        // R1: reset mid-run restores the seed and the prescaler
        period_i = 5'd1;
        pulses(7);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_sr  = 17'h00001;
        m_lvl = 1'b0;
        @(negedge clk);
        chk_state("R1 mid-run reset");
        pulses(16);
        @(negedge clk);
        model_step();
        chk_state("R1 restart from seed");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule